// File: doc/BRIEF.md
# PWM Compare Update Rate Controller

This block decides when a three-phase PWM generator takes new compare values. Software writes a repetition value and three compare preload values through a simple register port. An external PWM counter delivers one pulse per counted event. That is one full period in edge-aligned operation, or one half period in center-aligned operation. After every N+1 counted events, where N is the active repetition value, the block copies all three compare preloads into the active compare registers. At the same moment it emits a one-cycle update strobe and sets a sticky interrupt flag.

The repetition value is double-buffered. Software may rewrite it at any time, but the running down-counter only picks up the new value when it reloads at an update. When the peripheral enable goes from 0 to 1, the block forces an immediate update. That update loads the counter from the repetition preload, copies the compares and raises the interrupt. While the enable is low, the block ignores events entirely.

Top module: `pwm_rep_update`

## Requirements
- R1: After reset, every readable register reads 0, `act_cmp` is 0, and `upd_strobe` and `upd_irq` are 0.
- R2: Address 0 holds the 8-bit repetition preload. It reads back exactly what was last written. Addresses 1/3/5 hold the compare high bytes of phases 0/1/2, addresses 2/4/6 hold their low bytes, and address 7 reads 0.
- R3: In a compare low byte, only bits 7:3 are stored. Bits 2:0 ignore writes and always read 0.
- R4: A 0-to-1 change of `periph_en` forces an update on that clock edge. As a result, `upd_strobe` is high in the following cycle, `act_cmp` takes the preloads and `upd_irq` sets. A counted event in that same cycle is ignored, and the counter restarts from the repetition preload.
- R5: While enabled, the down-counter decrements on each `cnt_evt` pulse. An event that finds it at zero triggers an update and reloads the counter from the repetition preload. With value N, there is exactly one update per N+1 events.
- R6: `act_cmp` changes only on an update. Phase i occupies bits [13*i+12 : 13*i], laid out as {high byte, low-byte bits 7:3}. Preload writes are not visible on `act_cmp` until the next update.
- R7: A repetition write while enabled does not shorten or lengthen the count already running. It applies from the next reload onward.
- R8: `upd_irq` stays set until `irq_clr` is pulsed. If an update and a clear fall in the same cycle, the flag stays set.
- R9: While `periph_en` is 0, `cnt_evt` pulses are ignored and no update is produced.
- R10: With a repetition value of 0, every counted event produces an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; rising change forces an update |
| cnt_evt | input | 1 | One-cycle pulse per counted PWM period or half period |
| irq_clr | input | 1 | Clears the update interrupt flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| upd_strobe | output | 1 | One-cycle pulse after each update |
| upd_irq | output | 1 | Sticky update interrupt flag |
| act_cmp | output | 39 | Active compare values of the three phases |

## Verification
Two pairs of actions can collide in one clock. The first is an update and an interrupt clear. The bench provokes it by pulsing `irq_clr` together with a counted event at repetition 0, and it expects the flag to read 1 afterwards; a clear on its own must read 0. The second is the enable rise arriving with an event pulse. There the bench expects exactly one update, with the count restarted from the preload, and it checks this through the spacing of the strobes that follow. A scoreboard queues the expected compare vector for every update the requirements predict. It matches each strobe against that queue, which catches missed, extra and mistimed updates.

// File: rtl/pwm_rep_pkg.sv
package pwm_rep_pkg;

  // register address of the repetition preload
  localparam int unsigned REP_ADDR = 0;

  // compare high byte of phase i
  function automatic int unsigned addr_hi(input int unsigned ph);
    return 1 + 2 * ph;
  endfunction

  // compare low byte of phase i
  function automatic int unsigned addr_lo(input int unsigned ph);
    return 2 + 2 * ph;
  endfunction

endpackage

// File: rtl/pwm_rep_regs.sv
module pwm_rep_regs
  import pwm_rep_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int NUM_PH = 3,
  parameter int LO_RSV = 3,
  parameter int ADDR_W = 3,
  localparam int LO_W  = REG_W - LO_RSV,
  localparam int CMP_W = REG_W + LO_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [REG_W-1:0]        rd_data,
  output logic [REG_W-1:0]        rep_pre,
  output logic [NUM_PH*CMP_W-1:0] cmp_pre
);

  logic [REG_W-1:0] rep_q, rep_d;
  logic [REG_W-1:0] hi_arr [NUM_PH];
  logic [LO_W-1:0]  lo_arr [NUM_PH];

  always_comb begin
    rep_d = rep_q;
    if (wr_en && (wr_addr == ADDR_W'(REP_ADDR))) rep_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_q <= '0;
    else        rep_q <= rep_d;
  end

  assign rep_pre = rep_q;

  for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
    logic [REG_W-1:0] hi_q, hi_d;
    logic [LO_W-1:0]  lo_q, lo_d;

    always_comb begin
      hi_d = hi_q;
      lo_d = lo_q;
      if (wr_en && (wr_addr == ADDR_W'(addr_hi(g)))) hi_d = wr_data;
      // reserved low bits are dropped at the write
      if (wr_en && (wr_addr == ADDR_W'(addr_lo(g)))) lo_d = wr_data[REG_W-1:LO_RSV];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
    end

    assign hi_arr[g] = hi_q;
    assign lo_arr[g] = lo_q;
    assign cmp_pre[g*CMP_W +: CMP_W] = {hi_q, lo_q};
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(REP_ADDR)) rd_data = rep_q;
    for (int i = 0; i < NUM_PH; i++) begin
      if (rd_addr == ADDR_W'(addr_hi(i))) rd_data = hi_arr[i];
      if (rd_addr == ADDR_W'(addr_lo(i))) rd_data = {lo_arr[i], {LO_RSV{1'b0}}};
    end
  end

endmodule

// File: rtl/pwm_rep_seq.sv
module pwm_rep_seq #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             periph_en,
  input  logic             cnt_evt,
  input  logic [REG_W-1:0] rep_pre,
  output logic             upd_now
);

  logic             en_q, en_d;
  logic [REG_W-1:0] cnt_q, cnt_d;
  logic             force_upd, counted, wrap;

  // enable rise wins over a coincident event
  assign force_upd = periph_en & ~en_q;
  assign counted   = periph_en & en_q & cnt_evt;
  assign wrap      = counted & (cnt_q == '0);
  assign upd_now   = force_upd | wrap;

  always_comb begin
    en_d  = periph_en;
    cnt_d = cnt_q;
    if (upd_now)      cnt_d = rep_pre;
    else if (counted) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pwm_rep_active.sv
module pwm_rep_active #(
  parameter int NUM_PH = 3,
  parameter int CMP_W  = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_now,
  input  logic                    irq_clr,
  input  logic [NUM_PH*CMP_W-1:0] cmp_pre,
  output logic [NUM_PH*CMP_W-1:0] act_cmp,
  output logic                    upd_strobe,
  output logic                    upd_irq
);

  logic stb_q, stb_d, irq_q, irq_d;

  for (genvar g = 0; g < NUM_PH; g++) begin : g_act
    logic [CMP_W-1:0] act_q, act_d;

    always_comb begin
      act_d = act_q;
      if (upd_now) act_d = cmp_pre[g*CMP_W +: CMP_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= '0;
      else        act_q <= act_d;
    end

    assign act_cmp[g*CMP_W +: CMP_W] = act_q;
  end

  always_comb begin
    stb_d = upd_now;
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (upd_now) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
      irq_q <= irq_d;
    end
  end

  assign upd_strobe = stb_q;
  assign upd_irq    = irq_q;

endmodule

// File: rtl/pwm_rep_update.sv
module pwm_rep_update #(
  parameter int REG_W  = 8,
  parameter int NUM_PH = 3,
  parameter int LO_RSV = 3,
  parameter int ADDR_W = 3,
  localparam int CMP_W = 2 * REG_W - LO_RSV
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    periph_en,
  input  logic                    cnt_evt,
  input  logic                    irq_clr,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [REG_W-1:0]        rd_data,
  output logic                    upd_strobe,
  output logic                    upd_irq,
  output logic [NUM_PH*CMP_W-1:0] act_cmp
);

  logic [REG_W-1:0]        rep_pre;
  logic [NUM_PH*CMP_W-1:0] cmp_pre;
  logic                    upd_now;

  pwm_rep_regs #(
    .REG_W (REG_W),
    .NUM_PH(NUM_PH),
    .LO_RSV(LO_RSV),
    .ADDR_W(ADDR_W)
  ) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .rep_pre(rep_pre),
    .cmp_pre(cmp_pre)
  );

  pwm_rep_seq #(
    .REG_W(REG_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .periph_en(periph_en),
    .cnt_evt  (cnt_evt),
    .rep_pre  (rep_pre),
    .upd_now  (upd_now)
  );

  pwm_rep_active #(
    .NUM_PH(NUM_PH),
    .CMP_W (CMP_W)
  ) act_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_now   (upd_now),
    .irq_clr   (irq_clr),
    .cmp_pre   (cmp_pre),
    .act_cmp   (act_cmp),
    .upd_strobe(upd_strobe),
    .upd_irq   (upd_irq)
  );

endmodule

// File: rtl/pwm_rep_update_chk.sv
module pwm_rep_update_chk #(
  parameter int NUM_PH = 3,
  parameter int CMP_W  = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    periph_en,
  input logic                    irq_clr,
  input logic                    upd_now,
  input logic                    upd_strobe,
  input logic                    upd_irq,
  input logic [NUM_PH*CMP_W-1:0] cmp_pre,
  input logic [NUM_PH*CMP_W-1:0] act_cmp
);

  assert_enable_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_en) |=> upd_strobe);

  assert_cmp_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> (act_cmp == $past(cmp_pre)));

  assert_cmp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |-> $stable(act_cmp));

  assert_irq_on_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> upd_irq);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_irq && !irq_clr) |=> upd_irq);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !upd_now) |=> !upd_irq);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |=> !upd_strobe);

endmodule

bind pwm_rep_update pwm_rep_update_chk #(
  .NUM_PH(NUM_PH),
  .CMP_W (CMP_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .periph_en (periph_en),
  .irq_clr   (irq_clr),
  .upd_now   (upd_now),
  .upd_strobe(upd_strobe),
  .upd_irq   (upd_irq),
  .cmp_pre   (cmp_pre),
  .act_cmp   (act_cmp)
);

// File: tb/pwm_rep_update_tb_top.sv
`timescale 1ns/1ps
module pwm_rep_update_tb_top;

  localparam int REG_W  = 8;
  localparam int NPH    = 3;
  localparam int LO_RSV = 3;
  localparam int ADDR_W = 3;
  localparam int CMP_W  = 2 * REG_W - LO_RSV;
  localparam int VEC_W  = NPH * CMP_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_en = 1'b0, cnt_evt = 1'b0, irq_clr = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [REG_W-1:0]  wr_data = '0;
  logic [REG_W-1:0]  rd_data;
  logic              upd_strobe, upd_irq;
  logic [VEC_W-1:0]  act_cmp;

  always #2.5 clk = ~clk;

  pwm_rep_update #(.REG_W(REG_W), .NUM_PH(NPH), .LO_RSV(LO_RSV), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .cnt_evt(cnt_evt),
    .irq_clr(irq_clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .upd_strobe(upd_strobe),
    .upd_irq(upd_irq), .act_cmp(act_cmp)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  logic [VEC_W-1:0] exp_q[$];
  logic [CMP_W-1:0] cmp_m [NPH];
  logic [REG_W-1:0] rep_m = '0;
  int               cnt_m = 0;
  bit               en_m = 1'b0;

  initial for (int i = 0; i < NPH; i++) cmp_m[i] = '0;

  function automatic logic [VEC_W-1:0] pack_m();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < NPH; i++) v[i*CMP_W +: CMP_W] = cmp_m[i];
    return v;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // update predicted: queue the compare vector and reload the count
  task automatic model_update();
    exp_q.push_back(pack_m());
    cnt_m = rep_m;
  endtask

  task automatic reg_wr(input int addr, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr == 0) rep_m = data;
    else if (addr <= 2 * NPH) begin
      if (addr % 2 == 1) cmp_m[(addr-1)/2][CMP_W-1 -: REG_W] = data;
      else               cmp_m[(addr-1)/2][REG_W-LO_RSV-1:0] = data[7:LO_RSV];
    end
  endtask

  task automatic reg_rd_chk(input string tag, input int addr, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = ADDR_W'(addr);
    #1;
    check(tag, 64'(rd_data), 64'(exp));
  endtask

  task automatic evt(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cnt_evt = 1'b1;
      if (en_m) begin
        if (cnt_m == 0) model_update();
        else            cnt_m--;
      end
      @(negedge clk);
      cnt_evt = 1'b0;
    end
  endtask

  task automatic set_en(input bit v, input bit with_evt);
    @(negedge clk);
    periph_en = v;
    cnt_evt   = with_evt;
    if (v && !en_m) model_update();
    en_m = v;
    @(negedge clk);
    cnt_evt = 1'b0;
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    @(negedge clk);
    check(tag, 64'(exp_q.size()), 64'd0);
  endtask

  // monitor: every strobe must match the oldest predicted update
  always @(negedge clk) begin
    if (rst_n && upd_strobe) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5 unexpected update strobe actual=1 expected=0");
      end else begin
        logic [VEC_W-1:0] e;
        e = exp_q.pop_front();
        if (act_cmp !== e) begin
          n_fail++;
          $display("FAIL R6 act_cmp actual=%0h expected=%0h", act_cmp, e);
        end
        if (upd_irq !== 1'b1) begin
          n_fail++;
          $display("FAIL R8 irq with strobe actual=%0b expected=1", upd_irq);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_addr = ADDR_W'(a);
      #1;
      check("R1 reset read", 64'(rd_data), 64'd0);
    end
    check("R1 act_cmp", 64'(act_cmp), 64'd0);
    check("R1 irq", 64'(upd_irq), 64'd0);
    check("R1 strobe", 64'(upd_strobe), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R3 register access
    reg_wr(0, 8'd2);
    reg_rd_chk("R2 rep readback", 0, 8'd2);
    reg_wr(1, 8'hA5);
    reg_rd_chk("R2 hi readback", 1, 8'hA5);
    reg_wr(2, 8'hFF);
    reg_rd_chk("R3 lo reserved", 2, 8'hF8);
    reg_wr(3, 8'h3C);
    reg_wr(4, 8'h1F);
    reg_rd_chk("R3 lo reserved", 4, 8'h18);
    reg_wr(5, 8'h81);
    reg_wr(6, 8'h6E);
    reg_rd_chk("R3 lo reserved", 6, 8'h68);
    reg_rd_chk("R2 unused addr", 7, 8'h00);
    check("R6 no update while disabled", 64'(act_cmp), 64'd0);

    // R4 enable rise with a coincident event
    set_en(1'b1, 1'b1);
    drain("R4 forced update");
    check("R4 irq set", 64'(upd_irq), 64'd1);

    // R5 one update per three events at N=2
    evt(3);
    drain("R5 period N=2");
    reg_wr(1, 8'h5A);
    check("R6 preload hidden", 64'(act_cmp), 64'(pack_m() ^ exp_q.size()) ^ 64'(cmp_m[0] ^ {8'hA5, cmp_m[0][4:0]}));
    evt(3);
    drain("R6 new compare at update");

    // R7 repetition change mid-count, R10 N=0
    evt(1);
    reg_wr(0, 8'd0);
    evt(1);
    drain("R7 running count kept");
    evt(1);
    drain("R7 update at old end");
    evt(3);
    drain("R10 every event");

    // R8 clear alone, then clear colliding with an update
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0; #1;
    check("R8 clear alone", 64'(upd_irq), 64'd0);
    @(negedge clk);
    irq_clr = 1'b1; cnt_evt = 1'b1;
    model_update();
    @(negedge clk);
    irq_clr = 1'b0; cnt_evt = 1'b0; #1;
    check("R8 update wins", 64'(upd_irq), 64'd1);
    drain("R8 collision update");

    // R9 disabled: events ignored
    set_en(1'b0, 1'b0);
    evt(4);
    reg_wr(0, 8'd1);
    drain("R9 no updates");
    check("R9 strobe low", 64'(upd_strobe), 64'd0);
    set_en(1'b1, 1'b0);
    evt(4);
    drain("R5 period N=1 after enable");
    evt(1);
    drain("R8 sticky");
    check("R8 sticky", 64'(upd_irq), 64'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule